// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

The block gathers level-sensitive interrupt requests from up to 31 external sources and presents a single external-interrupt line to one hart context. Sources are numbered 1 to 31. Source 0 is a null entry that is never pending, never enabled and always has priority 0. Software sets up each source's priority (0 to 7), a word of per-source enable bits and a priority threshold. All of these sit on a simple 32-bit register bus with valid, write, byte address and write data signals.

When the interrupt line rises, the handler reads one shared claim/complete offset. This returns the best eligible source and moves it into service. While it is in service, that source is neither reported nor offered again, even if its request line stays high. Writing the same ID back to that offset ends service. The request can then become pending again. Completion writes naming a source that is not in service are dropped.

Top module: `irq_hub`

## Requirements
- R1: After reset all priorities, enable bits and the threshold read 0, no source is in service, `ext_irq_o` is low and a claim returns 0.
- R2: Source N has a priority register at byte offset 4*N (N = 1..31) holding write data bits [2:0]. Reads return that value zero-extended. Offset 0 always reads 0 and ignores writes.
- R3: The enable word is at offset 0x2000. Bit N gates source N, and bit 0 always reads 0.
- R4: The pending word is at offset 0x1000. Bit N is 1 when source N's request line was high at the previous clock edge and N is not in service. Writes to this offset have no effect.
- R5: The threshold is at offset 0x200000 and holds write data bits [2:0]. A source is eligible only if all of these hold: it is pending, it is enabled, its priority is nonzero, and its priority is greater than or equal to the threshold.
- R6: A read at offset 0x200004 returns the ID of the eligible source with the highest priority. Ties go to the lowest ID. The read returns 0 when no source is eligible.
- R7: A claimed source enters service. It is then not pending, not eligible and not returned by any claim until it is completed.
- R8: Writing the ID of an in-service source to offset 0x200004 ends its service. If its request is still high, it shows as pending again right after that write.
- R9: A completion write whose ID is not in service, including 0 and IDs of 32 or more, changes nothing.
- R10: `ext_irq_o` is high exactly when at least one source is eligible.
- R11: Read data appears on `rsp_rdata_o` after the clock edge that accepts the read, and holds until the next read. Address bits [1:0] are ignored. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Level request per source; bit N is source N, bit 0 unused |
| req_valid_i | input | 1 | Bus access strobe, one access per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Byte offset from the block base |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data |
| ext_irq_o | output | 1 | External interrupt line to the hart |

## Verification
The hardest state to reach is a source that is in service while its request line stays high. In that state the source must stay hidden from pending reads and claims. Once a valid completion arrives, it must reappear in the very next cycle, while bogus completions leave it hidden. Random stimulus holds request lines high across many bus operations and mixes claims with completion IDs drawn both from the bench's in-service set and from invalid values. Directed sequences also build priority ties and threshold edges so that the lowest-ID tie-break and the greater-or-equal comparison are both exercised.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned PRIO_W = 3;
  // word offsets (byte offset >> 2)
  localparam int unsigned PEND_WORD  = 32'h0000_0400;
  localparam int unsigned EN_WORD    = 32'h0000_0800;
  localparam int unsigned THR_WORD   = 32'h0008_0000;
  localparam int unsigned CLAIM_WORD = 32'h0008_0001;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/irq_hub_src.sv
module irq_hub_src #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              prio_we_i,
  input  logic [PRIO_W-1:0] prio_d_i,
  input  logic              en_we_i,
  input  logic              en_d_i,
  input  logic              claim_i,
  input  logic              done_i,
  input  logic [PRIO_W-1:0] thr_i,
  output logic [PRIO_W-1:0] prio_o,
  output logic              en_o,
  output logic              pend_o,
  output logic              svc_o,
  output logic              elig_o
);
  logic [PRIO_W-1:0] prio_q;
  logic en_q, pend_q, svc_q, svc_d;

  assign svc_d = (svc_q | claim_i) & ~done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      if (prio_we_i) prio_q <= prio_d_i;
      if (en_we_i)   en_q   <= en_d_i;
      pend_q <= req_i & ~svc_d;  // in-service masks the level request
      svc_q  <= svc_d;
    end
  end

  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign svc_o  = svc_q;
  assign elig_o = pend_q & en_q & (prio_q != '0) & (prio_q >= thr_i);

  AST_SVC_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_q |-> !elig_o && !pend_o);  // R7
  AST_DONE_NEEDS_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> svc_q);  // R9
  AST_CLAIM_NEEDS_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |-> elig_o);  // R6
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             elig_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]             win_id_o,
  output logic                        any_o
);
  logic [PRIO_W-1:0] best_p;

  // strict compare keeps the lowest ID on a tie; best_p starts at 0 so prio 0 never wins
  always_comb begin
    win_id_o = '0;
    best_p   = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig_i[i] && (prio_i[i] > best_p)) begin
        win_id_o = ID_W'(i);
        best_p   = prio_i[i];
      end
    end
  end

  assign any_o = |elig_i;
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              ext_irq_o
);
  import irq_hub_pkg::*;
  localparam int unsigned ID_W   = $clog2(NSRC);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  reg_sel_e          sel;
  logic [ID_W-1:0]   sel_id, win_id, done_id;
  logic              rd, wr, claim_rd, done_wr, done_hit, any_elig;
  logic [PRIO_W-1:0] thr_q;
  logic [31:0]       rdata_q, rdata_d;

  logic [NSRC-1:0][PRIO_W-1:0] prio_vec;
  logic [NSRC-1:0] en_vec, pend_vec, svc_vec, elig_vec;

  assign word   = req_addr_i[ADDR_W-1:2];
  assign sel_id = word[ID_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (word < WORD_W'(NSRC))              sel = SEL_PRIO;
    else if (word == WORD_W'(PEND_WORD))   sel = SEL_PEND;
    else if (word == WORD_W'(EN_WORD))     sel = SEL_EN;
    else if (word == WORD_W'(THR_WORD))    sel = SEL_THR;
    else if (word == WORD_W'(CLAIM_WORD))  sel = SEL_CLAIM;
  end

  assign rd       = req_valid_i & ~req_write_i;
  assign wr       = req_valid_i & req_write_i;
  assign claim_rd = rd & (sel == SEL_CLAIM);
  assign done_wr  = wr & (sel == SEL_CLAIM);
  assign done_id  = req_wdata_i[ID_W-1:0];
  assign done_hit = done_wr && (req_wdata_i < 32'(NSRC)) && svc_vec[done_id];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_null
      assign prio_vec[i] = '0;
      assign en_vec[i]   = 1'b0;
      assign pend_vec[i] = 1'b0;
      assign svc_vec[i]  = 1'b0;
      assign elig_vec[i] = 1'b0;
    end else begin : g_cell
      irq_hub_src #(.PRIO_W(PRIO_W)) u_src (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (irq_src_i[i]),
        .prio_we_i(wr && (sel == SEL_PRIO) && (sel_id == ID_W'(i))),
        .prio_d_i (req_wdata_i[PRIO_W-1:0]),
        .en_we_i  (wr && (sel == SEL_EN)),
        .en_d_i   (req_wdata_i[i]),
        .claim_i  (claim_rd && (win_id == ID_W'(i))),
        .done_i   (done_hit && (done_id == ID_W'(i))),
        .thr_i    (thr_q),
        .prio_o   (prio_vec[i]),
        .en_o     (en_vec[i]),
        .pend_o   (pend_vec[i]),
        .svc_o    (svc_vec[i]),
        .elig_o   (elig_vec[i])
      );
    end
  end

  irq_hub_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .elig_i  (elig_vec),
    .prio_i  (prio_vec),
    .win_id_o(win_id),
    .any_o   (any_elig)
  );

  always_comb begin
    unique case (sel)
      SEL_PRIO:  rdata_d = 32'(prio_vec[sel_id]);
      SEL_PEND:  rdata_d = 32'(pend_vec);
      SEL_EN:    rdata_d = 32'(en_vec);
      SEL_THR:   rdata_d = 32'(thr_q);
      SEL_CLAIM: rdata_d = 32'(win_id);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && (sel == SEL_THR)) thr_q <= req_wdata_i[PRIO_W-1:0];
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata_o = rdata_q;
  assign ext_irq_o   = any_elig;

  AST_WIN_IS_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_id == '0) || elig_vec[win_id]);  // R6
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_o == (win_id != '0));  // R10
  AST_CLAIM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rd && (win_id != '0) |=> svc_vec[$past(win_id)]);  // R7
  AST_BAD_DONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_wr && !done_hit |=> $stable(svc_vec));  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rsp_rdata_o));  // R11
endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
  localparam int unsigned NSRC = 32;
  localparam logic [21:0] A_PEND  = 22'h001000;
  localparam logic [21:0] A_EN    = 22'h002000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [21:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rsp_rdata_o;
  logic ext_irq_o;

  always #5 clk_i = ~clk_i;

  irq_hub dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_rdata_o(rsp_rdata_o), .ext_irq_o(ext_irq_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [2:0]  m_prio [NSRC];
  logic [31:0] m_en, m_svc, m_src;
  logic [2:0]  m_thr;

  function automatic logic [31:0] exp_pend();
    return m_src & ~m_svc & 32'hFFFF_FFFE;
  endfunction

  function automatic int exp_win();
    int best = 0;
    logic [2:0] bp = 0;
    logic [31:0] p = exp_pend();
    for (int i = 1; i < NSRC; i++)
      if (p[i] && m_en[i] && m_prio[i] != 0 && m_prio[i] >= m_thr && m_prio[i] > bp) begin
        best = i; bp = m_prio[i];
      end
    return best;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [21:0] a, input logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    irq_src_i = v; m_src = v;
    @(negedge clk_i);
  endtask

  task automatic set_prio(input int id, input logic [31:0] v);
    bus(1'b1, 22'(id * 4), v);
    if (id > 0 && id < NSRC) m_prio[id] = v[2:0];
  endtask

  task automatic set_en(input logic [31:0] v);
    bus(1'b1, A_EN, v);
    m_en = v & 32'hFFFF_FFFE;
  endtask

  task automatic set_thr(input logic [31:0] v);
    bus(1'b1, A_THR, v);
    m_thr = v[2:0];
  endtask

  task automatic do_claim(input string tag);
    int w = exp_win();
    bus(1'b0, A_CLAIM, 32'h0);
    check(tag, rsp_rdata_o, 32'(w));
    if (w != 0) m_svc[w] = 1'b1;
  endtask

  task automatic do_done(input logic [31:0] id);
    bus(1'b1, A_CLAIM, id);
    if (id < NSRC && m_svc[id[4:0]]) m_svc[id[4:0]] = 1'b0;
  endtask

  task automatic chk_pend(input string tag);
    bus(1'b0, A_PEND, 32'h0);
    check(tag, rsp_rdata_o, exp_pend());
  endtask

  task automatic chk_irq(input string tag);
    check(tag, 32'(ext_irq_o), 32'(exp_win() != 0));
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240917));
    for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
    m_en = 0; m_svc = 0; m_src = 0; m_thr = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 ext_irq", 32'(ext_irq_o), 0);
    bus(1'b0, 22'd20, 0);  check("R1 prio5", rsp_rdata_o, 0);
    bus(1'b0, A_EN, 0);    check("R1 enable", rsp_rdata_o, 0);
    bus(1'b0, A_THR, 0);   check("R1 thr", rsp_rdata_o, 0);
    do_claim("R1 claim");

    // R2 priority regs, null source, R11 hold
    set_prio(9, 32'hFFFF_FFF6);
    bus(1'b0, 22'd36, 0);  check("R2 prio9 3-bit", rsp_rdata_o, 32'd6);
    bus(1'b1, 22'd0, 32'd7);
    bus(1'b0, 22'd0, 0);   check("R2 prio0 hardwired", rsp_rdata_o, 0);
    bus(1'b0, 22'd39, 0);  check("R11 low addr bits ignored", rsp_rdata_o, 32'd6);
    bus(1'b1, 22'd36, 32'd6);
    check("R11 rdata held on write", rsp_rdata_o, 32'd6);

    // R3 enable word, bit 0
    set_en(32'hFFFF_FFFF);
    bus(1'b0, A_EN, 0);    check("R3 enable bit0 zero", rsp_rdata_o, 32'hFFFF_FFFE);

    // R6 tie to lowest ID, R7 service hides, R4 pending
    set_prio(3, 5); set_prio(7, 5); set_prio(9, 0);
    set_src(32'h0000_0288);  // sources 3, 7, 9
    chk_pend("R4 pending sources");
    check("R10 irq raised", 32'(ext_irq_o), 1);
    do_claim("R6 tie lowest id");
    check("R6 tie result is 3", rsp_rdata_o, 32'd3);
    do_claim("R7 next after 3 in service");
    check("R7 second claim 7", rsp_rdata_o, 32'd7);
    do_claim("R7 prio0 source 9 never wins");
    check("R7 none left", rsp_rdata_o, 0);
    chk_pend("R7 in-service not pending");
    check("R10 irq low", 32'(ext_irq_o), 0);

    // R9 bogus completions
    do_done(32'd9); do_done(32'd0); do_done(32'd35);
    chk_pend("R9 bogus completion");
    do_claim("R9 still nothing claimable");

    // R8 completion with line high
    do_done(32'd3);
    chk_pend("R8 re-pend after done");
    do_claim("R8 reclaim 3");
    check("R8 reclaim id", rsp_rdata_o, 32'd3);
    do_done(32'd3); do_done(32'd7);

    // R5 threshold edge
    set_src(32'h0000_0010);  // source 4
    set_prio(4, 2);
    set_thr(3);
    chk_irq("R5 below thr");
    check("R5 below thr blocked", 32'(ext_irq_o), 0);
    set_thr(2);
    check("R5 equal thr passes", 32'(ext_irq_o), 1);

    // R4 pending read-only, R11 unmapped
    bus(1'b1, A_PEND, 32'hFFFF_FFFF);
    chk_pend("R4 pending write ignored");
    bus(1'b1, 22'h100000, 32'd7);
    bus(1'b0, A_THR, 0);   check("R11 unmapped write ignored", rsp_rdata_o, 32'd2);
    bus(1'b0, 22'h003000, 0); check("R11 unmapped read zero", rsp_rdata_o, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 9)
        0: begin set_src($urandom & 32'hFFFF_FFFE); chk_pend("R4 random pend"); end
        1: begin
          int id = $urandom % NSRC;
          set_prio(id, $urandom);
          bus(1'b0, 22'(id * 4), 0);
          check("R2 random prio", rsp_rdata_o, 32'(m_prio[id]));
        end
        2: set_en($urandom);
        3: set_thr($urandom);
        4, 5: do_claim("R6 random claim");
        6: begin
          v = ($urandom % 2 == 1) ? ($urandom % 40) : 32'($urandom % NSRC);
          do_done(v);
          chk_pend("R8 R9 random done");
        end
        7: chk_pend("R4 random read");
        default: begin
          bus(1'b0, A_EN, 0);
          check("R3 random enable", rsp_rdata_o, m_en);
        end
      endcase
      chk_irq("R10 random irq");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule